// File: doc/BRIEF.md
# Registered Decimal Digit Adder

This block adds two binary-coded decimal digits and an incoming decimal carry. It returns one decimal digit and an outgoing decimal carry. Two binary adders do the work. The first adds the two operand digits and the carry input to form a 4-bit intermediate value and a binary carry. A detector then decides whether that intermediate result has left the decimal range. When it has, a selector feeds the constant six into the second adder, which adds it to the intermediate value. Otherwise the selector feeds zero.

The result passes through one register stage, so a result appears one clock after its operands. Wider decimal adders are made by joining instances through the carry pins. Operands above nine are not supported.

Top module: `bcd_digit_adder`

## Requirements
- R1: For operand digits 0 to 9, the registered sum digit equals (a + b + carry_in) mod 10, in plain 4-bit binary coding.
- R2: The registered carry output is 1 exactly when a + b + carry_in is 10 or more. It is the OR of the carries from the first and the second addition.
- R3: A correction is applied when the first adder carries out, or when its 4-bit result has bit 3 set together with bit 2 or bit 1, that is, when the result exceeds nine.
- R4: Outputs change only on the rising clock edge. The result for operands present at one edge is visible after that edge and not before it.
- R5: While the active-low reset is low, the sum digit and the carry output are 0.
- R6: The carry input enters the first addition, so 9 + 9 + 1 yields digit 9 with carry 1.
- R7: For operands 0 to 9, the sum digit never exceeds 9.
- R8: The correction term is exactly 6 when a correction is applied and exactly 0 otherwise. For example, 5 + 5 + 0 yields digit 0 with carry 1, and 0 + 0 + 0 yields digit 0 with carry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dig_a | input | 4 | First decimal operand digit |
| dig_b | input | 4 | Second decimal operand digit |
| carry_in | input | 1 | Decimal carry from the less significant digit |
| dig_sum | output | 4 | Registered decimal sum digit |
| carry_out | output | 1 | Registered decimal carry to the next digit |

## Verification
All one hundred digit pairs are applied with both carry-in values. This separates sums that need no fix (totals up to nine) from sums that are fixed by the bit-pattern term (totals ten to fifteen) and from sums that are fixed by the binary carry (totals sixteen to nineteen). Directed cases pin down the carry-input path at the largest total and check that the register holds its old value until the clock edge. A reset asserted partway through the run shows that the outputs clear at once.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
    localparam int DIGIT_W  = 4;
    localparam int DEC_MAX  = 9;
    localparam int CORR_VAL = 6;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t digit;
        logic   carry;
    } bcd_state_t;
endpackage

// File: rtl/bcd_ripple_add.sv
module bcd_ripple_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co
);
    logic [W:0] chain;

    assign chain[0] = ci;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign sum[g]     = op_x[g] ^ op_y[g] ^ chain[g];
        assign chain[g+1] = (op_x[g] & op_y[g]) | (op_x[g] & chain[g]) | (op_y[g] & chain[g]);
    end

    assign co = chain[W];
endmodule

// File: rtl/bcd_adjust_detect.sv
module bcd_adjust_detect #(
    parameter int W = 4
) (
    input  logic [W-1:0] partial,
    input  logic         bin_carry,
    output logic         fix_en
);
    // decimal overflow: binary carry, or bit 3 with bit 2 or bit 1
    assign fix_en = bin_carry | (partial[3] & (partial[2] | partial[1]));
endmodule

// File: rtl/bcd_corr_mux.sv
module bcd_corr_mux #(
    parameter int W    = 4,
    parameter int CORR = 6
) (
    input  logic         fix_en,
    output logic [W-1:0] corr
);
    localparam logic [W-1:0] CORR_W = W'(CORR);

    always_comb begin
        corr = fix_en ? CORR_W : '0;
    end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
    import bcd_add_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] dig_a,
    input  logic [3:0] dig_b,
    input  logic       carry_in,
    output logic [3:0] dig_sum,
    output logic       carry_out
);
    localparam int TOT_W = DIGIT_W + 1;

    digit_t     z_part;
    logic       z_carry;
    logic       fix_en;
    digit_t     corr;
    digit_t     fixed_sum;
    logic       fix_carry;
    bcd_state_t st_d, st_q;

    // first stage: binary sum including carry input
    bcd_ripple_add #(.W(DIGIT_W)) i_add_bin (
        .op_x (dig_a),
        .op_y (dig_b),
        .ci   (carry_in),
        .sum  (z_part),
        .co   (z_carry)
    );

    bcd_adjust_detect #(.W(DIGIT_W)) i_detect (
        .partial   (z_part),
        .bin_carry (z_carry),
        .fix_en    (fix_en)
    );

    bcd_corr_mux #(.W(DIGIT_W), .CORR(CORR_VAL)) i_corr (
        .fix_en (fix_en),
        .corr   (corr)
    );

    // second stage: add correction term
    bcd_ripple_add #(.W(DIGIT_W)) i_add_fix (
        .op_x (z_part),
        .op_y (corr),
        .ci   (1'b0),
        .sum  (fixed_sum),
        .co   (fix_carry)
    );

    always_comb begin
        st_d       = st_q;
        st_d.digit = fixed_sum;
        st_d.carry = z_carry | fix_carry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dig_sum   = st_q.digit;
    assign carry_out = st_q.carry;

    // reference total used only by the checks below
    logic [TOT_W-1:0] in_total;
    logic             in_valid;
    assign in_total = TOT_W'(dig_a) + TOT_W'(dig_b) + TOT_W'(carry_in);
    assign in_valid = (int'(dig_a) <= DEC_MAX) && (int'(dig_b) <= DEC_MAX);

    assert_adjust_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fix_en == (z_carry || (int'(z_part) > DEC_MAX)));

    assert_corr_values_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fix_en ? (int'(corr) == CORR_VAL) : (corr == '0));

    assert_digit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (int'(dig_sum) == ($past(int'(in_total)) % 10)));

    assert_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (carry_out == ($past(int'(in_total)) >= 10)));

    assert_digit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (int'(dig_sum) <= DEC_MAX));

    assert_reset_clear_R5: assert property (@(posedge clk)
        !rst_n |-> (dig_sum == '0 && !carry_out));
endmodule

// File: tb/test_bcd_digit_adder.sv
module test_bcd_digit_adder;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] a, b;
    logic       cin;
    logic [3:0] sum;
    logic       cout;

    always #10 clk = ~clk;

    bcd_digit_adder i_bcd_digit_adder (
        .clk       (clk),
        .rst_n     (rst_n),
        .dig_a     (a),
        .dig_b     (b),
        .carry_in  (cin),
        .dig_sum   (sum),
        .carry_out (cout)
    );

    typedef struct {
        int    s;
        int    c;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(int ai, int bi, int ci, string tag);
        int tot;
        @(negedge clk);
        a   = 4'(ai);
        b   = 4'(bi);
        cin = 1'(ci);
        tot = ai + bi + ci;
        exp_q.push_back('{tot % 10, (tot >= 10) ? 1 : 0, tag});
    endtask

    // monitor: compare one cycle after each drive, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " R1 digit"}, int'(sum), e.s);
                check({e.tag, " R2 carry"}, int'(cout), e.c);
                check({e.tag, " R7 range"}, (int'(sum) <= 9) ? 1 : 0, 1);
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        a = 4'd7; b = 4'd8; cin = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 reset digit", int'(sum), 0);
        check("R5 reset carry", int'(cout), 0);
        rst_n = 1'b1;

        // R8: no correction and correction-by-pattern cases
        drive(0, 0, 0, "R8 zero");
        drive(5, 5, 0, "R8 six");
        // exhaustive sweep, R3 covers both correction sources
        for (int ci = 0; ci < 2; ci++) begin
            for (int ai = 0; ai < 10; ai++) begin
                for (int bi = 0; bi < 10; bi++) begin
                    drive(ai, bi, ci, "R3 sweep");
                end
            end
        end
        drive(9, 9, 1, "R6 max");
        @(posedge clk);
        #5;
        wait (exp_q.size() == 0);

        // R4: new operands are not visible before the clock edge
        @(negedge clk);
        a = 4'd2; b = 4'd2; cin = 1'b0;
        #1;
        check("R4 hold digit", int'(sum), 9);
        check("R4 hold carry", int'(cout), 1);
        @(posedge clk);
        #5;
        check("R4 update digit", int'(sum), 4);
        check("R4 update carry", int'(cout), 0);

        // R5: reset in mid-run clears at once
        @(negedge clk);
        a = 4'd9; b = 4'd4; cin = 1'b0;
        @(posedge clk);
        #5;
        check("R2 pre-reset carry", int'(cout), 1);
        rst_n = 1'b0;
        #1;
        check("R5 async digit", int'(sum), 0);
        check("R5 async carry", int'(cout), 0);
        @(posedge clk);
        #5;
        check("R5 held digit", int'(sum), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule